// File: doc/BRIEF.md
# Configurable Parallel Camera Capture Front-End

This block sits between an external camera's parallel pixel bus and the rest of the chip. It turns that bus into a clean pixel stream in the internal clock domain. The pixel clock, data lines, sync lines and field line are all oversampled by the internal clock through a two-flop stage. An edge detector on the sampled pixel clock then decides when a pixel is taken. Run-time configuration inputs control several aspects of the capture:

- which physical data lines form the pixel: a contiguous run of lines, given by a lowest line and a line count;
- whether the data is inverted;
- the active level of each sync signal;
- which pixel-clock edge captures data.

Frame timing comes from one of three sources, chosen by configuration:

- the camera's own sync lines;
- start/end codes embedded in the data stream, used when no sync polarity is configured;
- a timing generator inside the block, when the block is the sync master and drives the syncs out to the camera.

The output is a one-cycle valid pulse carrying the pixel, a start-of-frame flag, an end-of-line flag and an even-field flag. End-of-line is known only once the next sample shows blanking. For that reason every pixel is held back by one sample before it is emitted.

Top module: `vidCapture`

## Requirements
- R1: The pixel is input lines `cfgShift + cfgWidth - 1` down to `cfgShift`, right-aligned on `pixData`, with every bit at or above `cfgWidth` zero (width 8 and shift 2 take lines 9..2).
- R2: With `cfgDataAct` = 0 the selected lines are inverted before output; with 1 they pass unchanged. Bits above `cfgWidth` stay zero either way.
- R3: With `cfgRiseEdge` = 1 data is captured when the pixel clock goes from 0 to 1; with 0 it is captured when the pixel clock goes from 1 to 0. Data present at the other edge is never used.
- R4: With external sync selected (`cfgSyncEn` = 1, `cfgSlave` = 0), a sync input is active when it equals `cfgHsAct` / `cfgVsAct`. A sample is a pixel only when both syncs are inactive.
- R5: `pixSof` marks the first pixel after a sample with vertical sync active, or after a vertical-blanking code in embedded mode. `pixEol` marks a pixel whose following sample is not a pixel.
- R6: In external and master-timing modes, `pixEven` is 1 when the field input sampled with the pixel equals `cfgEvenLvl`.
- R7: With `cfgSyncEn` = 0 and `cfgSlave` = 0, the low byte of the pixel is scanned for the code FF, 00, 00, XY, where XY bit 4 is H, bit 5 is V and bit 6 is F. The rules are:
  - a code with H = 0 and V = 0 starts active video;
  - a byte of FF ends active video;
  - the code bytes themselves are never pixels;
  - a code with V = 1 arms start-of-frame;
  - `pixEven` equals the last F.
- R8: With `cfgSlave` = 1 the block counts capture edges over a line of `cfgActPix + cfgHBlank` samples and a frame of `cfgActLines + cfgVBlank` lines. `hsyncOut` is at level `cfgHsAct` in horizontal blanking and at the opposite level otherwise; `vsyncOut` behaves the same way in vertical blanking with `cfgVsAct`. Samples in the active window are pixels, and start-of-frame falls on position (0,0). The sync outputs change only after a capture edge.
- R9: With `cfgSlave` = 0, `hsyncOut` and `vsyncOut` rest at the inactive level, the opposite of `cfgHsAct` / `cfgVsAct`.
- R10: After reset `pixValid`, `pixSof`, `pixEol`, `pixEven` and `pixData` are zero, and `pixValid` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pclkIn | input | 1 | Camera pixel clock, oversampled |
| dataIn | input | LINES (12) | Physical data lines |
| hsyncIn | input | 1 | Horizontal sync from camera |
| vsyncIn | input | 1 | Vertical sync from camera |
| fieldIn | input | 1 | Field indicator from camera |
| cfgWidth | input | $clog2(PIXW+1) (4) | Number of data lines used |
| cfgShift | input | $clog2(LINES) (4) | Lowest data line used |
| cfgRiseEdge | input | 1 | 1 = rising capture edge, 0 = falling |
| cfgDataAct | input | 1 | 0 = data inverted, 1 = data true |
| cfgHsAct | input | 1 | Active level of horizontal sync |
| cfgVsAct | input | 1 | Active level of vertical sync |
| cfgSyncEn | input | 1 | 1 = sync polarities configured (external sync), 0 = embedded codes |
| cfgEvenLvl | input | 1 | Field input level marking the even field |
| cfgSlave | input | 1 | 1 = block generates and drives syncs |
| cfgActPix | input | CW (12) | Active samples per line (master timing) |
| cfgHBlank | input | CW (12) | Horizontal blanking samples |
| cfgActLines | input | CW (12) | Active lines per frame |
| cfgVBlank | input | CW (12) | Vertical blanking lines |
| hsyncOut | output | 1 | Generated horizontal sync |
| vsyncOut | output | 1 | Generated vertical sync |
| pixValid | output | 1 | One-cycle pixel strobe |
| pixData | output | PIXW (10) | Pixel value |
| pixSof | output | 1 | First pixel of a frame |
| pixEol | output | 1 | Last pixel of a line |
| pixEven | output | 1 | Pixel belongs to the even field |

## Verification
The bench changes the data lines between the capture edge and the opposite edge. A block that captures on the wrong edge therefore emits the complemented value. Shifted, narrowed and inverted pixels are compared bit for bit, so an off-by-one in the line window or an inversion that spills past the width shows up as wrong upper bits. The embedded-code scan is driven with codes that end lines and frames. A decoder that lets code bytes through as pixels, misreads the V or F bit, or keeps active video on after FF produces extra or mislabelled items in the scoreboard. In master-timing mode the sync outputs are compared at every sample position, which exposes miscounted blanking or a swapped polarity.

// File: rtl/vcapPkg.sv
package vcapPkg;
  typedef enum logic [1:0] {
    MODE_EXT  = 2'd0,
    MODE_EMB  = 2'd1,
    MODE_SLV  = 2'd2
  } vcapModeT;

  typedef struct packed {
    logic take;
    logic act;
    logic sof;
    logic even;
  } vcapStrobeT;
endpackage

// File: rtl/vcapDatapath.sv
module vcapDatapath
  import vcapPkg::*;
#(
  parameter int LINES = 12,
  parameter int PIXW  = 10,
  parameter int WW    = $clog2(PIXW + 1),
  parameter int SW    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] dataIn,
  input  logic [WW-1:0]    cfgWidth,
  input  logic [SW-1:0]    cfgShift,
  input  logic             cfgDataAct,
  input  vcapStrobeT       strobe,
  output logic [PIXW-1:0]  pixSel,
  output logic             pixValid,
  output logic [PIXW-1:0]  pixData,
  output logic             pixSof,
  output logic             pixEol,
  output logic             pixEven
);
  logic [LINES-1:0] dSync1, dSync2, shifted;
  logic [PIXW-1:0]  widthMask, rawPix;
  logic             pendValid, pendSof, pendEven;
  logic [PIXW-1:0]  pendData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dSync1 <= '0;
      dSync2 <= '0;
    end else begin
      dSync1 <= dataIn;
      dSync2 <= dSync1;
    end
  end

  always_comb begin
    for (int i = 0; i < PIXW; i++) begin
      widthMask[i] = (i < int'(cfgWidth));
    end
    shifted = dSync2 >> cfgShift;
    rawPix  = shifted[PIXW-1:0];
    pixSel  = (cfgDataAct ? rawPix : ~rawPix) & widthMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendData  <= '0;
      pendSof   <= 1'b0;
      pendEven  <= 1'b0;
      pixValid  <= 1'b0;
      pixData   <= '0;
      pixSof    <= 1'b0;
      pixEol    <= 1'b0;
      pixEven   <= 1'b0;
    end else begin
      pixValid <= 1'b0;
      pixSof   <= 1'b0;
      pixEol   <= 1'b0;
      if (strobe.take) begin
        if (pendValid) begin
          pixValid <= 1'b1;
          pixData  <= pendData;
          pixSof   <= pendSof;
          pixEol   <= !strobe.act;
          pixEven  <= pendEven;
        end
        pendValid <= strobe.act;
        if (strobe.act) begin
          pendData <= pixSel;
          pendSof  <= strobe.sof;
          pendEven <= strobe.even;
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> !pixValid); // R10

  AST_FLAGS_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (pixSof || pixEol) |-> pixValid); // R5

  AST_DATA_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && $stable(cfgWidth)) |-> ((pixData & ~widthMask) == '0)); // R1
endmodule

// File: rtl/vcapCtrl.sv
module vcapCtrl
  import vcapPkg::*;
#(
  parameter int PIXW = 10,
  parameter int CW   = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pclkIn,
  input  logic            hsyncIn,
  input  logic            vsyncIn,
  input  logic            fieldIn,
  input  logic [PIXW-1:0] pixSel,
  input  logic            cfgRiseEdge,
  input  logic            cfgHsAct,
  input  logic            cfgVsAct,
  input  logic            cfgSyncEn,
  input  logic            cfgEvenLvl,
  input  logic            cfgSlave,
  input  logic [CW-1:0]   cfgActPix,
  input  logic [CW-1:0]   cfgHBlank,
  input  logic [CW-1:0]   cfgActLines,
  input  logic [CW-1:0]   cfgVBlank,
  output vcapStrobeT      strobe,
  output logic            hsyncOut,
  output logic            vsyncOut
);
  localparam int CODEW = 8;

  logic pc1, pc2, pc3, hs1, hs2, vs1, vs2, fd1, fd2;
  logic take, hsA, vsA, isFF, isZero;
  logic [CODEW-1:0] codeByte;
  vcapModeT mode;
  logic [1:0] preState;
  logic inVid, fieldF, sofPend, setSof;
  logic [CW-1:0] hCnt, vCnt;
  logic [CW:0] hLast, vLast;
  logic hBlankNow, vBlankNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {pc1, pc2, pc3, hs1, hs2, vs1, vs2, fd1, fd2} <= '0;
    end else begin
      pc1 <= pclkIn;  pc2 <= pc1;  pc3 <= pc2;
      hs1 <= hsyncIn; hs2 <= hs1;
      vs1 <= vsyncIn; vs2 <= vs1;
      fd1 <= fieldIn; fd2 <= fd1;
    end
  end

  assign take     = (pc2 != pc3) && (pc2 == cfgRiseEdge);
  assign hsA      = (hs2 == cfgHsAct);
  assign vsA      = (vs2 == cfgVsAct);
  assign codeByte = pixSel[CODEW-1:0];
  assign isFF     = (codeByte == 8'hFF);
  assign isZero   = (codeByte == 8'h00);
  assign mode     = cfgSlave ? MODE_SLV : (cfgSyncEn ? MODE_EXT : MODE_EMB);
  assign hLast    = {1'b0, cfgActPix} + {1'b0, cfgHBlank} - 1'b1;
  assign vLast    = {1'b0, cfgActLines} + {1'b0, cfgVBlank} - 1'b1;
  assign hBlankNow = (hCnt >= cfgActPix);
  assign vBlankNow = (vCnt >= cfgActLines);

  always_comb begin
    strobe.take = take;
    strobe.act  = 1'b0;
    strobe.sof  = 1'b0;
    strobe.even = (fd2 == cfgEvenLvl);
    setSof      = 1'b0;
    unique case (mode)
      MODE_SLV: begin
        strobe.act = !hBlankNow && !vBlankNow;
        strobe.sof = strobe.act && (hCnt == '0) && (vCnt == '0);
      end
      MODE_EXT: begin
        strobe.act = !hsA && !vsA;
        strobe.sof = strobe.act && sofPend;
        setSof     = vsA;
      end
      default: begin
        strobe.act  = inVid && (preState == 2'd0) && !isFF;
        strobe.sof  = strobe.act && sofPend;
        strobe.even = fieldF;
        setSof      = (preState == 2'd3) && codeByte[5];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sofPend  <= 1'b0;
      preState <= 2'd0;
      inVid    <= 1'b0;
      fieldF   <= 1'b0;
    end else if (take) begin
      if (setSof)          sofPend <= 1'b1;
      else if (strobe.act) sofPend <= 1'b0;
      if (mode == MODE_EMB) begin
        unique case (preState)
          2'd0:    preState <= isFF ? 2'd1 : 2'd0;
          2'd1:    preState <= isZero ? 2'd2 : (isFF ? 2'd1 : 2'd0);
          2'd2:    preState <= isZero ? 2'd3 : (isFF ? 2'd1 : 2'd0);
          default: preState <= 2'd0;
        endcase
        if (preState == 2'd3) begin
          inVid  <= !codeByte[4] && !codeByte[5];
          fieldF <= codeByte[6];
        end else if (isFF) begin
          inVid <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (!cfgSlave) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (take) begin
      if ({1'b0, hCnt} >= hLast) begin
        hCnt <= '0;
        vCnt <= ({1'b0, vCnt} >= vLast) ? '0 : vCnt + 1'b1;
      end else begin
        hCnt <= hCnt + 1'b1;
      end
    end
  end

  assign hsyncOut = (cfgSlave && hBlankNow) ? cfgHsAct : !cfgHsAct;
  assign vsyncOut = (cfgSlave && vBlankNow) ? cfgVsAct : !cfgVsAct;

  AST_SLAVE_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSlave && !take) |=> (!cfgSlave || !$stable(cfgActPix) || !$stable(cfgHsAct)
                             || $stable(hsyncOut))); // R8
endmodule

// File: rtl/vidCapture.sv
module vidCapture
  import vcapPkg::*;
#(
  parameter int LINES = 12,
  parameter int PIXW  = 10,
  parameter int CW    = 12,
  localparam int WW   = $clog2(PIXW + 1),
  localparam int SW   = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pclkIn,
  input  logic [LINES-1:0] dataIn,
  input  logic             hsyncIn,
  input  logic             vsyncIn,
  input  logic             fieldIn,
  input  logic [WW-1:0]    cfgWidth,
  input  logic [SW-1:0]    cfgShift,
  input  logic             cfgRiseEdge,
  input  logic             cfgDataAct,
  input  logic             cfgHsAct,
  input  logic             cfgVsAct,
  input  logic             cfgSyncEn,
  input  logic             cfgEvenLvl,
  input  logic             cfgSlave,
  input  logic [CW-1:0]    cfgActPix,
  input  logic [CW-1:0]    cfgHBlank,
  input  logic [CW-1:0]    cfgActLines,
  input  logic [CW-1:0]    cfgVBlank,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             pixValid,
  output logic [PIXW-1:0]  pixData,
  output logic             pixSof,
  output logic             pixEol,
  output logic             pixEven
);
  vcapStrobeT      strobe;
  logic [PIXW-1:0] pixSel;

  vcapDatapath #(.LINES(LINES), .PIXW(PIXW), .WW(WW), .SW(SW)) uDatapath (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .cfgWidth(cfgWidth),
    .cfgShift(cfgShift), .cfgDataAct(cfgDataAct), .strobe(strobe),
    .pixSel(pixSel), .pixValid(pixValid), .pixData(pixData),
    .pixSof(pixSof), .pixEol(pixEol), .pixEven(pixEven)
  );

  vcapCtrl #(.PIXW(PIXW), .CW(CW)) uCtrl (
    .clk(clk), .rstN(rstN), .pclkIn(pclkIn), .hsyncIn(hsyncIn),
    .vsyncIn(vsyncIn), .fieldIn(fieldIn), .pixSel(pixSel),
    .cfgRiseEdge(cfgRiseEdge), .cfgHsAct(cfgHsAct), .cfgVsAct(cfgVsAct),
    .cfgSyncEn(cfgSyncEn), .cfgEvenLvl(cfgEvenLvl), .cfgSlave(cfgSlave),
    .cfgActPix(cfgActPix), .cfgHBlank(cfgHBlank), .cfgActLines(cfgActLines),
    .cfgVBlank(cfgVBlank), .strobe(strobe), .hsyncOut(hsyncOut),
    .vsyncOut(vsyncOut)
  );

  AST_EMB_NO_FF: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !cfgSlave && !cfgSyncEn && $stable(cfgSyncEn) && $stable(cfgSlave)
     && (cfgWidth >= 4'd8)) |-> (pixData[7:0] != 8'hFF)); // R7

  AST_MASTER_SYNC_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgSlave && $stable(cfgSlave)) |-> (hsyncOut != cfgHsAct && vsyncOut != cfgVsAct)); // R9
endmodule

// File: tb/test_vidCapture.sv
module test_vidCapture;
  localparam int LINES = 12;
  localparam int PIXW  = 10;
  localparam int CW    = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pclkIn = 1'b0;
  logic [LINES-1:0] dataIn = '0;
  logic hsyncIn = 1'b0, vsyncIn = 1'b0, fieldIn = 1'b0;
  logic [3:0] cfgWidth = 4'd8;
  logic [3:0] cfgShift = 4'd2;
  logic cfgRiseEdge = 1'b1, cfgDataAct = 1'b1, cfgHsAct = 1'b0, cfgVsAct = 1'b0;
  logic cfgSyncEn = 1'b1, cfgEvenLvl = 1'b1, cfgSlave = 1'b0;
  logic [CW-1:0] cfgActPix = 12'd3, cfgHBlank = 12'd2, cfgActLines = 12'd2, cfgVBlank = 12'd1;
  logic hsyncOut, vsyncOut, pixValid, pixSof, pixEol, pixEven;
  logic [PIXW-1:0] pixData;

  always #4 clk = ~clk;

  vidCapture i_vidCapture (
    .clk(clk), .rstN(rstN), .pclkIn(pclkIn), .dataIn(dataIn),
    .hsyncIn(hsyncIn), .vsyncIn(vsyncIn), .fieldIn(fieldIn),
    .cfgWidth(cfgWidth), .cfgShift(cfgShift), .cfgRiseEdge(cfgRiseEdge),
    .cfgDataAct(cfgDataAct), .cfgHsAct(cfgHsAct), .cfgVsAct(cfgVsAct),
    .cfgSyncEn(cfgSyncEn), .cfgEvenLvl(cfgEvenLvl), .cfgSlave(cfgSlave),
    .cfgActPix(cfgActPix), .cfgHBlank(cfgHBlank), .cfgActLines(cfgActLines),
    .cfgVBlank(cfgVBlank), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .pixValid(pixValid), .pixData(pixData), .pixSof(pixSof),
    .pixEol(pixEol), .pixEven(pixEven)
  );

  typedef struct {
    logic [PIXW-1:0] data;
    logic sof, eol, even;
    string tag;
  } expItemT;

  expItemT expQ[$];
  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [PIXW-1:0] expPix(input logic [LINES-1:0] d);
    logic [LINES-1:0] sh;
    logic [PIXW-1:0] v;
    sh = d >> cfgShift;
    v = cfgDataAct ? sh[PIXW-1:0] : ~sh[PIXW-1:0];
    for (int i = 0; i < PIXW; i++) if (i >= int'(cfgWidth)) v[i] = 1'b0;
    return v;
  endfunction

  task automatic pushExp(input logic [LINES-1:0] d, input bit sof, input bit eol,
                         input bit even, input string tag);
    expItemT it;
    it.data = expPix(d); it.sof = sof; it.eol = eol; it.even = even; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: pops the scoreboard on every output strobe
  always @(negedge clk) begin
    if (rstN && pixValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5", "unexpected pixel", int'(pixData), 0);
      end else begin
        expItemT e;
        e = expQ.pop_front();
        check(pixData == e.data && pixSof == e.sof && pixEol == e.eol && pixEven == e.even,
              e.tag, "pixel {data,sof,eol,even}",
              int'({pixData, pixSof, pixEol, pixEven}),
              int'({e.data, e.sof, e.eol, e.even}));
      end
    end
  end

  // Driver: one pixel period; lines change after the capture edge so a wrong-edge design sees ~d
  task automatic sendPix(input logic [LINES-1:0] d, input bit hBlank, input bit vBlank,
                         input bit fld);
    @(negedge clk);
    dataIn  = d;
    hsyncIn = hBlank ? cfgHsAct : !cfgHsAct;
    vsyncIn = vBlank ? cfgVsAct : !cfgVsAct;
    fieldIn = fld;
    repeat (3) @(negedge clk);
    pclkIn = cfgRiseEdge;
    repeat (3) @(negedge clk);
    dataIn = ~d;
    repeat (2) @(negedge clk);
    pclkIn = !cfgRiseEdge;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendCode(input logic [7:0] xy);
    sendPix(12'h0FF, 0, 0, 0);
    sendPix(12'h000, 0, 0, 0);
    sendPix(12'h000, 0, 0, 0);
    sendPix({4'h0, xy}, 0, 0, 0);
  endtask

  task automatic doReset();
    repeat (6) @(negedge clk);
    check(expQ.size() == 0, "R5", "scoreboard drained", expQ.size(), 0);
    expQ.delete();
    rstN = 1'b0;
    pclkIn = !cfgRiseEdge;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    // Reset state, master mode: R10, R9
    pclkIn = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(pixValid == 0 && pixSof == 0 && pixEol == 0 && pixEven == 0 && pixData == 0,
          "R10", "outputs after reset", int'({pixValid, pixData}), 0);
    check(hsyncOut == 1'b1 && vsyncOut == 1'b1, "R9", "idle syncs in master mode",
          int'({hsyncOut, vsyncOut}), 3);

    // External sync, width 8 shift 2, active-low syncs: R1, R4, R5, R6
    sendPix(12'h123, 1, 1, 1);
    sendPix(12'h456, 1, 0, 1);
    sendPix(12'h3FC, 0, 0, 1); pushExp(12'h3FC, 1, 0, 1, "R1");
    sendPix(12'hA5A, 0, 0, 1); pushExp(12'hA5A, 0, 0, 1, "R4");
    sendPix(12'h00F, 0, 0, 1); pushExp(12'h00F, 0, 1, 1, "R5");
    sendPix(12'hFFF, 1, 0, 1);
    sendPix(12'h804, 0, 0, 1); pushExp(12'h804, 0, 0, 1, "R1");
    sendPix(12'h7F3, 0, 0, 1); pushExp(12'h7F3, 0, 1, 1, "R5");
    sendPix(12'h555, 0, 1, 1);
    check(hsyncOut == 1'b1 && vsyncOut == 1'b1, "R9", "syncs stay idle during capture",
          int'({hsyncOut, vsyncOut}), 3);

    // Inverted data, width 6 shift 3, active-high syncs, odd field: R2, R4, R6
    cfgDataAct = 0; cfgWidth = 4'd6; cfgShift = 4'd3; cfgHsAct = 1; cfgVsAct = 1;
    doReset();
    sendPix(12'h000, 1, 1, 0);
    sendPix(12'h0F8, 0, 0, 0); pushExp(12'h0F8, 1, 0, 0, "R2");
    sendPix(12'hC47, 0, 0, 0); pushExp(12'hC47, 0, 0, 0, "R6");
    sendPix(12'h3A1, 0, 0, 0); pushExp(12'h3A1, 0, 1, 0, "R4");
    sendPix(12'h111, 1, 0, 0);

    // Falling capture edge, full width 10: R3
    cfgDataAct = 1; cfgWidth = 4'd10; cfgShift = 4'd1; cfgRiseEdge = 0; cfgEvenLvl = 0;
    doReset();
    sendPix(12'h000, 1, 1, 0);
    sendPix(12'h6B2, 0, 0, 0); pushExp(12'h6B2, 1, 0, 1, "R3");
    sendPix(12'h19C, 0, 0, 0); pushExp(12'h19C, 0, 1, 1, "R3");
    sendPix(12'h000, 1, 0, 0);

    // Embedded codes: R7
    cfgRiseEdge = 1; cfgWidth = 4'd8; cfgShift = 4'd0; cfgSyncEn = 0; cfgEvenLvl = 1;
    doReset();
    sendCode(8'h30);
    sendCode(8'h40);
    sendPix(12'h010, 0, 0, 0); pushExp(12'h010, 1, 0, 1, "R7");
    sendPix(12'h020, 0, 0, 0); pushExp(12'h020, 0, 0, 1, "R7");
    sendPix(12'h030, 0, 0, 0); pushExp(12'h030, 0, 1, 1, "R7");
    sendCode(8'h50);
    sendCode(8'h40);
    sendPix(12'h055, 0, 0, 0); pushExp(12'h055, 0, 0, 1, "R7");
    sendPix(12'h066, 0, 0, 0); pushExp(12'h066, 0, 1, 1, "R7");
    sendCode(8'h50);
    sendCode(8'h20);
    sendCode(8'h00);
    sendPix(12'h007, 0, 0, 0); pushExp(12'h007, 1, 0, 0, "R7");
    sendPix(12'h008, 0, 0, 0); pushExp(12'h008, 0, 1, 0, "R7");
    sendCode(8'h10);

    // Sync master: 3 active + 2 blank samples, 2 active + 1 blank lines: R8
    cfgSlave = 1; cfgSyncEn = 1; cfgHsAct = 1; cfgVsAct = 0;
    doReset();
    for (int p = 0; p < 17; p++) begin
      int hC, vC;
      bit actNext;
      hC = p % 5;
      vC = (p / 5) % 3;
      check(hsyncOut == ((hC >= 3) ? 1'b1 : 1'b0), "R8", "generated hsync level",
            int'(hsyncOut), (hC >= 3) ? 1 : 0);
      check(vsyncOut == ((vC >= 2) ? 1'b0 : 1'b1), "R8", "generated vsync level",
            int'(vsyncOut), (vC >= 2) ? 0 : 1);
      actNext = ((p + 1) % 5 < 3) && (((p + 1) / 5) % 3 < 2);
      if (hC < 3 && vC < 2 && p < 16) begin
        pushExp(12'(p + 1), (hC == 0 && vC == 0), !actNext, 1, "R8");
      end
      sendPix(12'(p + 1), 0, 0, 1);
    end
    cfgSlave = 0;
    doReset();

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule